// File: doc/BRIEF.md
# Fractional/Integer 17x17 Multiplier

This block is the multiply stage shared by a DSP accumulate path and the ordinary integer multiply instructions of a processor datapath. It takes two 16-bit operands, and each one carries its own flag saying whether it is signed. Each operand is widened by one bit according to that flag. The two 17-bit values are then multiplied in one step. A mode bit picks how the 32-bit result is presented. In integer mode it is the plain product. In fractional mode it is the product doubled, so that two 1.15 operands give a 1.31 result directly. The single case that cannot be represented, minus one times minus one, is clamped to the largest positive value.

The block also drives a 40-bit copy of the result, sign-extended from the top bit of the 32-bit product, ready for an accumulator with guard bits. Accumulation, rounding and saturation of the accumulator are handled elsewhere. The datapath is combinational. A parameter selects whether one output register with synchronous active-high reset follows it. The register is selected by default.

Top module: `qmul_unit`

## Requirements
- R1: A signed operand is widened by copying its most significant bit. An unsigned operand is widened with a zero. Examples: signed 0xFFFF times signed 0x0001 in integer mode gives 0xFFFFFFFF, and the same operands both unsigned give 0x0000FFFF.
- R2: With `frac_mode` = 0 (integer), `prod_o` is the low 32 bits of the product of the two widened operands, with no scaling. Unsigned 0xFFFF times unsigned 0xFFFF gives 0xFFFE0001, and a zero operand gives zero.
- R3: With `frac_mode` = 1 (fractional), `prod_o` is the product shifted left by one bit, keeping 32 bits. Signed 0x4000 times signed 0x4000 gives 0x20000000, and bit 0 is zero except in the clamp case of R4.
- R4: In fractional mode, when both operands are signed and both equal 0x8000, `prod_o` is 0x7FFFFFFF. The same operands in integer mode give 0x40000000. When either operand is unsigned no clamp applies: signed 0x8000 times unsigned 0x8000 gives 0x80000000 in fractional mode.
- R5: `acc_o` equals `prod_o` in its low 32 bits, and bits 39..32 are copies of `prod_o` bit 31.
- R6: With OUT_REG = 1, the outputs show the result of the inputs sampled at the previous rising clock edge. With OUT_REG = 0, the outputs follow the inputs with no clock.
- R7: With OUT_REG = 1, a rising edge with `rst` high clears `prod_o` and `acc_o` to zero, whatever the inputs are.
- R8: The two signedness flags act independently. Signed 0x8000 times unsigned 0x8000 gives 0xC0000000 in integer mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | OP_W (16) | First operand |
| op_b | input | OP_W (16) | Second operand |
| a_is_signed | input | 1 | 1: `op_a` is two's complement; 0: unsigned |
| b_is_signed | input | 1 | 1: `op_b` is two's complement; 0: unsigned |
| frac_mode | input | 1 | 1: fractional (doubled, clamped) result; 0: integer result |
| prod_o | output | 2*OP_W (32) | Product in the selected format |
| acc_o | output | ACC_W (40) | `prod_o` sign-extended to accumulator width |

## Verification
The bench builds three instances. The first uses the default 16-bit operands with the output register, and the second uses the same width without the register. Between them they cover the clamp, the mixed-sign cases, unsigned extremes, reset clearing and the one-cycle offset against the unregistered copy. The third uses 5-bit operands with an 18-bit accumulator output. That width makes every operand pair under all four signedness combinations and both modes small enough to sweep exhaustively, so every sign-extension path and the clamp boundary are reached at a scaled width.

// File: rtl/qmul_pkg.sv
package qmul_pkg;
  // Result presentation selected by the mode input.
  typedef enum logic {
    QMUL_INTEGER    = 1'b0,
    QMUL_FRACTIONAL = 1'b1
  } qmul_mode_e;
endpackage

// File: rtl/qmul_opext.sv
// Widens one operand by a single bit according to its signedness flag.
module qmul_opext #(
  parameter int OP_W = 16,
  localparam int EXT_W = OP_W + 1
) (
  input  logic [OP_W-1:0]  op_in,
  input  logic             is_signed,
  output logic [EXT_W-1:0] op_ext
);
  assign op_ext = {is_signed & op_in[OP_W-1], op_in};
endmodule

// File: rtl/qmul_core.sv
// Signed (OP_W+1)x(OP_W+1) multiply with integer or doubled-and-clamped output.
module qmul_core
  import qmul_pkg::*;
#(
  parameter int OP_W = 16,
  localparam int EXT_W  = OP_W + 1,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic [EXT_W-1:0]  ext_a,
  input  logic [EXT_W-1:0]  ext_b,
  input  logic              frac_mode,
  output logic [PROD_W-1:0] prod
);
  // Widened form of the most negative signed operand.
  localparam logic [EXT_W-1:0]  NEG_MIN = {2'b11, {(OP_W-1){1'b0}}};
  localparam logic [PROD_W-1:0] POS_MAX = {1'b0, {(PROD_W-1){1'b1}}};

  logic signed [PROD_W-1:0] full;
  logic                     clamp;
  qmul_mode_e               mode;

  // Both widened operands are signed. The product is kept modulo 2^PROD_W,
  // which holds every representable result of the 17x17 multiply.
  assign full  = PROD_W'($signed(ext_a)) * PROD_W'($signed(ext_b));
  assign clamp = (ext_a == NEG_MIN) && (ext_b == NEG_MIN);
  assign mode  = qmul_mode_e'(frac_mode);

  always_comb begin
    case (mode)
      QMUL_FRACTIONAL: prod = clamp ? POS_MAX : {full[PROD_W-2:0], 1'b0};
      default:         prod = full;
    endcase
  end
endmodule

// File: rtl/qmul_outreg.sv
// Optional output stage: a register with synchronous reset, or a wire.
module qmul_outreg #(
  parameter int W  = 32,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/qmul_unit.sv
// Fractional/integer multiplier with per-operand signedness and accumulator-width output.
module qmul_unit #(
  parameter int OP_W    = 16,
  parameter int ACC_W   = 40,
  parameter bit OUT_REG = 1'b1,
  localparam int EXT_W   = OP_W + 1,
  localparam int PROD_W  = 2 * OP_W,
  localparam int GUARD_W = ACC_W - PROD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic              a_is_signed,
  input  logic              b_is_signed,
  input  logic              frac_mode,
  output logic [PROD_W-1:0] prod_o,
  output logic [ACC_W-1:0]  acc_o
);
  logic [EXT_W-1:0]  ext_a;
  logic [EXT_W-1:0]  ext_b;
  logic [PROD_W-1:0] prod_c;

  qmul_opext #(.OP_W(OP_W)) u_ext_a (
    .op_in(op_a), .is_signed(a_is_signed), .op_ext(ext_a)
  );

  qmul_opext #(.OP_W(OP_W)) u_ext_b (
    .op_in(op_b), .is_signed(b_is_signed), .op_ext(ext_b)
  );

  qmul_core #(.OP_W(OP_W)) u_core (
    .ext_a(ext_a), .ext_b(ext_b), .frac_mode(frac_mode), .prod(prod_c)
  );

  // Only the narrow product is stored. The guard bits are derived after the register.
  qmul_outreg #(.W(PROD_W), .EN(OUT_REG)) u_outreg (
    .clk(clk), .rst(rst), .d(prod_c), .q(prod_o)
  );

  assign acc_o = {{GUARD_W{prod_o[PROD_W-1]}}, prod_o};
endmodule

// File: rtl/qmul_unit_chk.sv
// Property checker for qmul_unit, attached by bind.
module qmul_unit_chk #(
  parameter int OP_W    = 16,
  parameter int ACC_W   = 40,
  parameter bit OUT_REG = 1'b1,
  localparam int PROD_W = 2 * OP_W
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic              a_is_signed,
  input logic              b_is_signed,
  input logic              frac_mode,
  input logic [PROD_W-1:0] prod_o,
  input logic [ACC_W-1:0]  acc_o
);
  localparam logic [OP_W-1:0]   MIN_OP  = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [PROD_W-1:0] POS_MAX = {1'b0, {(PROD_W-1){1'b1}}};

  // Inputs aligned with the outputs they produced.
  logic [OP_W-1:0] d_a, d_b;
  logic            d_as, d_bs, d_fm, d_ok;
  logic            clamp_case;

  generate
    if (OUT_REG) begin : g_lat
      always_ff @(posedge clk) begin
        d_a  <= op_a;
        d_b  <= op_b;
        d_as <= a_is_signed;
        d_bs <= b_is_signed;
        d_fm <= frac_mode;
        d_ok <= !rst;
      end

      // R7: a reset edge leaves the output cleared.
      p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prod_o == '0 && acc_o == '0));
    end else begin : g_comb
      always_comb begin
        d_a  = op_a;
        d_b  = op_b;
        d_as = a_is_signed;
        d_bs = b_is_signed;
        d_fm = frac_mode;
        d_ok = 1'b1;
      end
    end
  endgenerate

  assign clamp_case = d_as && d_bs && d_fm && (d_a == MIN_OP) && (d_b == MIN_OP);

  // R2: a zero operand gives zero in either mode.
  p_zero_operand_r2: assert property (@(posedge clk) disable iff (rst)
    d_ok && (d_a == '0 || d_b == '0) |-> prod_o == '0);

  // R2: unsigned integer product matches plain arithmetic.
  p_uint_product_r2: assert property (@(posedge clk) disable iff (rst)
    d_ok && !d_fm && !d_as && !d_bs |-> prod_o == PROD_W'(d_a) * PROD_W'(d_b));

  // R3: a doubled result has a zero low bit.
  p_frac_lsb_r3: assert property (@(posedge clk) disable iff (rst)
    d_ok && d_fm && !clamp_case |-> prod_o[0] == 1'b0);

  // R4: minus one squared is clamped.
  p_clamp_r4: assert property (@(posedge clk) disable iff (rst)
    d_ok && clamp_case |-> prod_o == POS_MAX);

  // R5: the guard bits and bit 31 are all equal.
  p_acc_ext_r5: assert property (@(posedge clk) disable iff (rst)
    (&acc_o[ACC_W-1:PROD_W-1]) || !(|acc_o[ACC_W-1:PROD_W-1]));
endmodule

bind qmul_unit qmul_unit_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
  .a_is_signed(a_is_signed), .b_is_signed(b_is_signed), .frac_mode(frac_mode),
  .prod_o(prod_o), .acc_o(acc_o)
);

// File: tb/qmul_unit_bench.sv
module qmul_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Full-width stimulus, shared by the registered and unregistered instances.
  logic [15:0] a16 = '0, b16 = '0;
  logic        as16 = 1'b0, bs16 = 1'b0, fm16 = 1'b0;
  logic [31:0] prod16, prodc;
  logic [39:0] acc16, accc;

  // Small configuration for the exhaustive sweep.
  logic [4:0]  a5 = '0, b5 = '0;
  logic        as5 = 1'b0, bs5 = 1'b0, fm5 = 1'b0;
  logic [9:0]  prod5;
  logic [17:0] acc5;

  qmul_unit u_qmul_unit (
    .clk(clk), .rst(rst), .op_a(a16), .op_b(b16),
    .a_is_signed(as16), .b_is_signed(bs16), .frac_mode(fm16),
    .prod_o(prod16), .acc_o(acc16)
  );

  qmul_unit #(.OUT_REG(1'b0)) u_qmul_unit_comb (
    .clk(clk), .rst(rst), .op_a(a16), .op_b(b16),
    .a_is_signed(as16), .b_is_signed(bs16), .frac_mode(fm16),
    .prod_o(prodc), .acc_o(accc)
  );

  qmul_unit #(.OP_W(5), .ACC_W(18)) u_qmul_unit_small (
    .clk(clk), .rst(rst), .op_a(a5), .op_b(b5),
    .a_is_signed(as5), .b_is_signed(bs5), .frac_mode(fm5),
    .prod_o(prod5), .acc_o(acc5)
  );

  function automatic longint unsigned ref_prod(int w, longint unsigned a, longint unsigned b,
                                               bit sa_f, bit sb_f, bit fm);
    longint sa, sb, p;
    longint unsigned mask, minv, r;
    mask = (longint'(1) << (2 * w)) - 1;
    minv = longint'(1) << (w - 1);
    sa = (sa_f && a[w-1]) ? longint'(a) - (longint'(1) << w) : longint'(a);
    sb = (sb_f && b[w-1]) ? longint'(b) - (longint'(1) << w) : longint'(b);
    p  = sa * sb;
    if (fm && sa_f && sb_f && a == minv && b == minv)
      r = (longint'(1) << (2 * w - 1)) - 1;
    else if (fm)
      r = longint'(p) << 1;
    else
      r = longint'(p);
    return r & mask;
  endfunction

  function automatic longint unsigned ref_acc(int w, int accw, longint unsigned p);
    longint unsigned pmask, amask;
    pmask = (longint'(1) << (2 * w)) - 1;
    amask = (longint'(1) << accw) - 1;
    return p[2*w-1] ? ((p | ~pmask) & amask) : p;
  endfunction

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive16(logic [15:0] a, logic [15:0] b, bit sa, bit sb, bit fm);
    @(negedge clk);
    a16 = a; b16 = b; as16 = sa; bs16 = sb; fm16 = fm;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R7: reset clears the registered outputs while inputs are nonzero.
    rst = 1'b1;
    drive16(16'h1234, 16'h5678, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R7 prod under reset", prod16, 0);
    check("R7 acc under reset", acc16, 0);
    // R6: the unregistered copy already shows the product.
    check("R6 comb follows inputs", prodc, 32'h06260060);
    @(negedge clk);
    rst = 1'b0;

    // R1: sign copy versus zero fill.
    drive16(16'hFFFF, 16'h0001, 1'b1, 1'b1, 1'b0);
    check("R1 signed widen", prod16, 32'hFFFFFFFF);
    check("R5 acc negative", acc16, 40'hFFFFFFFFFF);
    drive16(16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0);
    check("R1 unsigned widen", prod16, 32'h0000FFFF);
    check("R5 acc positive", acc16, 40'h000000FFFF);

    // R2: unsigned maximum, integer mode, and zero operand.
    drive16(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    check("R2 unsigned max", prod16, 32'hFFFE0001);
    check("R5 acc of bit31 set", acc16, 40'hFFFFFE0001);
    drive16(16'h0000, 16'h8000, 1'b1, 1'b1, 1'b1);
    check("R2 zero operand", prod16, 0);

    // R3: 0.5 * 0.5 = 0.25 in 1.31.
    drive16(16'h4000, 16'h4000, 1'b1, 1'b1, 1'b1);
    check("R3 frac half squared", prod16, 32'h20000000);
    drive16(16'hC000, 16'h4000, 1'b1, 1'b1, 1'b1);
    check("R3 frac negative", prod16, 32'hE0000000);

    // R4: clamp only for both signed in fractional mode.
    drive16(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1);
    check("R4 frac clamp", prod16, 32'h7FFFFFFF);
    check("R4 acc of clamp", acc16, 40'h007FFFFFFF);
    drive16(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0);
    check("R4 integer no clamp", prod16, 32'h40000000);
    drive16(16'h8000, 16'h8000, 1'b1, 1'b0, 1'b1);
    check("R4 mixed frac no clamp", prod16, 32'h80000000);

    // R8: independent signedness flags.
    drive16(16'h8000, 16'h8000, 1'b1, 1'b0, 1'b0);
    check("R8 signed a unsigned b", prod16, 32'hC0000000);
    drive16(16'h8000, 16'h8000, 1'b0, 1'b1, 1'b0);
    check("R8 unsigned a signed b", prod16, 32'hC0000000);

    // R6: one-cycle offset of the registered output.
    @(negedge clk);
    a16 = 16'h0003; b16 = 16'h0005; as16 = 1'b0; bs16 = 1'b0; fm16 = 1'b0;
    #1;
    check("R6 reg holds before edge", prod16, 32'hC0000000);
    check("R6 comb updates at once", prodc, 32'h0000000F);
    @(posedge clk); #1;
    check("R6 reg after edge", prod16, 32'h0000000F);

    // Exhaustive sweep of the 5-bit configuration: R1, R2, R3, R4, R5, R8.
    for (int mode = 0; mode < 8; mode++) begin
      for (int a = 0; a < 32; a++) begin
        for (int b = 0; b < 32; b++) begin
          longint unsigned ep, ea;
          @(negedge clk);
          a5 = 5'(a); b5 = 5'(b);
          as5 = mode[0]; bs5 = mode[1]; fm5 = mode[2];
          @(posedge clk); #1;
          ep = ref_prod(5, longint'(a), longint'(b), mode[0], mode[1], mode[2]);
          ea = ref_acc(5, 18, ep);
          check(mode[2] ? "R3/R4 sweep product" : "R2/R8 sweep product", prod5, ep);
          check("R5 sweep acc", acc5, ea);
        end
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule